// File: doc/BRIEF.md
# Seven-to-one lane-mapped parallel serializer

The block takes a 28-bit parallel word once per word-clock period and sends it out as four serial data lanes of seven bits each. A fifth output carries a clock pattern at word rate. The whole block runs on a bit clock that is seven times the word clock and in phase with it. The word clock is treated as a plain input. It is sampled on the bit clock, and the chosen edge (rising or falling, picked by a select input) yields a one-cycle strobe. That strobe captures the word and realigns the seven-slot frame counter.

Each lane carries a fixed set of input bits that is not in index order, and it sends them in a fixed sequence. The captured word waits in a holding register and moves into the lane shift registers only at a frame boundary. A frame is therefore never changed while it is being shifted out. An active-low shutdown input clears every register and forces all outputs low. After release, a valid flag rises when the first frame built from a freshly captured word begins.

Top module: `lane_serializer7`

## Requirements
- R1: While `shutdown_ni` is low, `lane_o`, `clk_lane_o` and `valid_o` are 0 from the first bit-clock sample after it falls, and every register is cleared. The same holds while `rst_ni` is low.
- R2: When `edge_rise_i` is 1, the word clock's rising transitions are the capture edges. When it is 0, its falling transitions are. Transitions of the other polarity start no frame and capture no word.
- R3: Lane 0 (`lane_o[0]`) sends input bits 7, 6, 4, 3, 2, 1, 0 in slots 0 to 6.
- R4: Lane 1 (`lane_o[1]`) sends input bits 18, 15, 14, 13, 12, 9, 8 in slots 0 to 6.
- R5: Lane 2 (`lane_o[2]`) sends input bits 26, 25, 24, 22, 21, 20, 19 in slots 0 to 6.
- R6: Lane 3 (`lane_o[3]`) sends input bits 23, 17, 16, 11, 10, 5, 27 in slots 0 to 6.
- R7: In every valid frame, `clk_lane_o` is 1 in slots 0 to 3 and 0 in slots 4 to 6.
- R8: Suppose a selected word-clock transition is present at bit-clock edge n. The frame counter is then set so that slot 0 is output after edge n+1, whatever its phase was before. That frame carries the word captured at the previous selected transition.
- R9: After reset or shutdown release, `valid_o`, the lanes and the clock lane stay 0 until a frame built from a word captured after the release begins. `valid_o` then rises together with that frame's slot 0 and stays 1.
- R10: `data_i` is sampled only at edge n+1 following a selected transition at edge n. Its value at every other edge has no effect on any lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the word rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shutdown_ni | input | 1 | Active-low shutdown, clears state and silences outputs |
| word_clk_i | input | 1 | Word clock, sampled on clk_i |
| edge_rise_i | input | 1 | 1: capture on rising word-clock edge, 0: on falling |
| data_i | input | 28 | Parallel input word |
| lane_o | output | 4 | Serial data lanes, one bit per slot |
| clk_lane_o | output | 1 | Word-rate clock pattern, high for slots 0 to 3 |
| valid_o | output | 1 | Frames on the lanes carry captured data |

## Verification
The stimulus uses single-bit words at the positions that are out of place in their lane (bit 27 last on lane 3, bit 5 next to last), plus dense and alternating patterns. A swapped or mirrored lane map would then put a lone one in the wrong slot or on the wrong lane. Between capture points, `data_i` is driven with the complement of the word. A design that fed the shift registers straight from the input, or loaded the holding register on every cycle, would therefore send corrupted frames. Both edge polarities are run. In the falling-edge run, the word clock sits high at shutdown release, so a design that reacted to the wrong polarity would start a frame at the spurious rising edge. The runs start at an arbitrary counter phase after release, so a design that did not realign its counter, or that raised `valid_o` on an empty holding register, would show misplaced clock-lane pulses or early data.

// File: rtl/lser_pkg.sv
package lser_pkg;
  localparam int unsigned WORD_W = 28;
  localparam int unsigned LANES  = 4;
  localparam int unsigned SLOTS  = 7;
  localparam int unsigned CLK_HI = 4;

  // input bit index per lane, in transmission order
  localparam int LANE_MAP [4][7] = '{
    '{ 7,  6,  4,  3,  2,  1,  0},
    '{18, 15, 14, 13, 12,  9,  8},
    '{26, 25, 24, 22, 21, 20, 19},
    '{23, 17, 16, 11, 10,  5, 27}
  };
endpackage

// File: rtl/lser_edge_det.sv
module lser_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic wc_i,
  input  logic rise_sel_i,
  output logic stb_o
);
  logic wc_q, wc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q <= 1'b0;
      wc_d <= 1'b0;
    end else if (!clr_ni) begin
      wc_q <= 1'b0;
      wc_d <= 1'b0;
    end else begin
      wc_q <= wc_i;
      wc_d <= wc_q;
    end
  end

  always_comb begin
    if (rise_sel_i) stb_o = clr_ni & wc_q & ~wc_d;
    else            stb_o = clr_ni & ~wc_q & wc_d;
  end

  // R2: a selected edge cannot repeat on the next cycle under a stable select
  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !(stb_o && $stable(rise_sel_i)));
endmodule

// File: rtl/lser_framer.sv
module lser_framer #(
  parameter int unsigned WORD_W = lser_pkg::WORD_W,
  parameter int unsigned SLOTS  = lser_pkg::SLOTS,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              stb_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              load_o,
  output logic [WORD_W-1:0] hold_o,
  output logic              valid_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] hold_q;
  logic              full_q, valid_q;

  assign load_o  = stb_i | (slot_q == LAST);
  assign slot_o  = slot_q;
  assign hold_o  = hold_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      hold_q  <= '0;
      full_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (!clr_ni) begin
      slot_q  <= '0;
      hold_q  <= '0;
      full_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      slot_q <= load_o ? '0 : slot_q + 1'b1;
      if (stb_i) begin
        hold_q <= data_i;
        full_q <= 1'b1;
      end
      // frame from a captured word starts shifting
      if (load_o && full_q) valid_q <= 1'b1;
    end
  end

  // R8: a strobe restarts the frame at slot 0
  a_r8_realign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> (slot_q == '0));
  // R9: valid rises only at a frame start
  a_r9_valid_at_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (slot_q == '0));
  // R10: holding register changes only on a capture strobe
  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_i && clr_ni) ##1 clr_ni |-> $stable(hold_q));
  // R1: shutdown clears the valid state
  a_r1_shutdown_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> !valid_q);
endmodule

// File: rtl/lser_lane.sv
module lser_lane #(
  parameter int unsigned WORD_W = lser_pkg::WORD_W,
  parameter int unsigned SLOTS  = lser_pkg::SLOTS,
  parameter int unsigned LANE   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [SLOTS-1:0] sr_q, mapped;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      mapped[SLOTS-1-s] = word_i[lser_pkg::LANE_MAP[LANE][s]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (!clr_ni) sr_q <= '0;
    else if (load_i)  sr_q <= mapped;
    else              sr_q <= {sr_q[SLOTS-2:0], 1'b0};
  end

  assign bit_o = sr_q[SLOTS-1];
endmodule

// File: rtl/lane_serializer7.sv
module lane_serializer7 #(
  parameter int unsigned WORD_W = lser_pkg::WORD_W,
  parameter int unsigned LANES  = lser_pkg::LANES,
  parameter int unsigned SLOTS  = lser_pkg::SLOTS,
  parameter int unsigned CLK_HI = lser_pkg::CLK_HI,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shutdown_ni,
  input  logic              word_clk_i,
  input  logic              edge_rise_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [LANES-1:0]  lane_o,
  output logic              clk_lane_o,
  output logic              valid_o
);
  logic              stb, load, valid;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] hold;
  logic [LANES-1:0]  bits;

  lser_edge_det u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_ni    (shutdown_ni),
    .wc_i      (word_clk_i),
    .rise_sel_i(edge_rise_i),
    .stb_o     (stb)
  );

  lser_framer #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_framer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (shutdown_ni),
    .stb_i  (stb),
    .data_i (data_i),
    .slot_o (slot),
    .load_o (load),
    .hold_o (hold),
    .valid_o(valid)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lser_lane #(.WORD_W(WORD_W), .SLOTS(SLOTS), .LANE(l)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_ni(shutdown_ni),
      .load_i(load),
      .word_i(hold),
      .bit_o (bits[l])
    );
  end

  assign valid_o    = valid;
  assign lane_o     = (shutdown_ni && valid) ? bits : '0;
  assign clk_lane_o = shutdown_ni & valid & (slot < SLOT_W'(CLK_HI));

  // R7: clock lane rises only at a frame load
  a_r7_clk_rise_at_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_lane_o) |-> $past(load));
endmodule

// File: tb/tb_lane_serializer7.sv
module tb_lane_serializer7;
  localparam logic [27:0] VEC [8] = '{
    28'h0000001, 28'h8000000, 28'h0000020, 28'hFFFFFFF,
    28'hAAAAAAA, 28'h5555555, 28'h1234567, 28'h0F0F0F0
  };
  localparam int MAP [4][7] = '{
    '{ 7,  6,  4,  3,  2,  1,  0},
    '{18, 15, 14, 13, 12,  9,  8},
    '{26, 25, 24, 22, 21, 20, 19},
    '{23, 17, 16, 11, 10,  5, 27}
  };

  logic        clk = 1'b0;
  logic        rst_ni, shutdown_ni, word_clk_i, edge_rise_i;
  logic [27:0] data_i;
  logic [3:0]  lane_o;
  logic        clk_lane_o, valid_o;

  always #4 clk = ~clk;

  lane_serializer7 dut (
    .clk_i(clk), .rst_ni(rst_ni), .shutdown_ni(shutdown_ni),
    .word_clk_i(word_clk_i), .edge_rise_i(edge_rise_i), .data_i(data_i),
    .lane_o(lane_o), .clk_lane_o(clk_lane_o), .valid_o(valid_o)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [27:0] hist [16];
  string lane_tag [4] = '{"R3", "R4", "R5", "R6"};

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_off(string tag);
    chk(tag, int'(lane_o), 0);
    chk(tag, int'(clk_lane_o), 0);
    chk(tag, int'(valid_o), 0);
  endtask

  // period k, cycle c: frame f, slot s, content hist[f-1]
  task automatic sample(int k, int c, bit rise);
    int f = (c >= 2) ? k : k - 1;
    int s = (c + 5) % 7;
    logic [27:0] w;
    if (f >= 1) begin
      w = hist[f-1];
      for (int l = 0; l < 4; l++)
        chk({lane_tag[l], "/R8/R10"}, int'(lane_o[l]), int'(w[MAP[l][s]]));
      chk(rise ? "R7" : "R2/R7", int'(clk_lane_o), (s < 4) ? 1 : 0);
      chk("R9", int'(valid_o), 1);
    end else begin
      chk(rise ? "R9" : "R2/R9", int'(lane_o), 0);
      chk("R9", int'(clk_lane_o), 0);
      chk("R9", int'(valid_o), 0);
    end
  endtask

  task automatic stream(int n, bit rise, bit rev);
    for (int k = 0; k < n + 2; k++) begin
      logic [27:0] word = (k < n) ? VEC[rev ? 7 - k : k] : 28'h0;
      hist[k] = word;
      for (int c = 0; c < 7; c++) begin
        @(negedge clk);
        sample(k, c, rise);
        word_clk_i = rise ? (c < 4) : !(c < 4);
        data_i     = (c < 2) ? word : ~word;
      end
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; shutdown_ni = 1'b1; word_clk_i = 1'b0;
    edge_rise_i = 1'b1; data_i = '0;
    repeat (3) @(negedge clk);
    chk_off("R1");
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_off("R9");
    end
    stream(8, 1'b1, 1'b0);

    // shutdown mid-run with data on the lanes
    @(negedge clk);
    shutdown_ni = 1'b0;
    data_i = 28'hFFFFFFF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_off("R1");
    end
    edge_rise_i = 1'b0;
    word_clk_i  = 1'b1;
    @(negedge clk);
    chk_off("R1");
    shutdown_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_off("R9");
    end
    stream(6, 1'b0, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule